// File: doc/BRIEF.md
# I2C Addressed Transfer Sequencer

This block runs a whole register-addressed I2C transaction over a byte-level bus controller. It does not generate SCL or SDA timing itself. It issues one byte-level operation at a time on a command port: START plus a byte, write a byte, read a byte, or STOP. It then waits for the controller to report completion. A request names a direction, a 7-bit device address, a register address of 0 to 4 bytes, and a data byte count. Write data is taken from a show-ahead byte input. Read data leaves as one pulse per byte. A result code is returned in the cycle the transaction finishes.

Both directions first wait for the bus to go idle.

A write sends a START with the device address and a write bit. It then sends the register address bytes, most significant first, followed by the data bytes and a STOP.

A read with a register address starts the same way. After the address bytes it issues a repeated START carrying the read bit. It then reads the data, acknowledging every byte except the last one. With no register address, a read goes straight to the START with the read bit. A one-byte read of this kind serves as a presence probe.

An overflow mask can fold register-address bits that lie above the transmitted address bytes into the low device-address bits.

The states are:
- `ST_IDLE`: waits for `start`.
- `ST_BUSWAIT`: waits for the bus to be free.
- `ST_DEVW`: START with the write address.
- `ST_REGA`: register address bytes.
- `ST_RSTART`: START with the read address.
- `ST_DATW`: data writes.
- `ST_DATR`: data reads.
- `ST_STOP`: issues STOP.
- `ST_DONE`: one-cycle result.

The transitions are:
- **accept**: `ST_IDLE` to `ST_BUSWAIT`.
- **reject**: `ST_IDLE` to `ST_DONE`.
- **bus free**: to `ST_DEVW`, or to `ST_RSTART` for a read without an address.
- **bus timeout**: `ST_BUSWAIT` to `ST_DONE`.
- **byte ok**: to the next phase, or to `ST_STOP` after the last data byte.
- **byte nack** and **byte timeout**: to `ST_STOP`.
- **arbitration lost**: to `ST_DONE`.
- **stop complete**: to `ST_DONE`.
- **release**: `ST_DONE` to `ST_IDLE`.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A request with `data_len` = 0 or `addr_len` > 4 finishes with result 1 (bad request) in the cycle after `start`. No bus operation is issued.
- R2: Before the first operation the block waits for `bus_busy` to be low. If it stays high for `WAIT_LIMIT` cycles, the result is 4 (timeout) and no operation is issued.
- R3: A write issues the following, then ends with result 0:
  - START with byte {device, 0};
  - `addr_len` register address bytes;
  - `data_len` bytes of write data, each taken from `tx_byte` with a `tx_take` pulse;
  - STOP.
- R4: With `addr_len` = 0 a write sends no register address bytes.
- R5: A read with `addr_len` > 0 issues the following, then ends with result 0:
  - START with byte {device, 0};
  - the register address bytes;
  - START with byte {device, 1};
  - `data_len` READ operations;
  - STOP.
- R6: A read with `addr_len` = 0 starts directly with START and byte {device, 1}. A one-byte probe of this form returns 0 when acknowledged and 2 when not.
- R7: A READ operation drives `ctl_ack` = 1 (acknowledge) for every data byte except the last, which uses `ctl_ack` = 0.
- R8: A not-acknowledged START or written byte ends the transaction with result 2. The next operation is STOP. A NACK flag on a READ completion is ignored.
- R9: Arbitration loss on any completion ends the transaction with result 3 and no further operation, not even STOP.
- R10: If an issued operation gets no completion within `WAIT_LIMIT` cycles, the result is 4 and STOP is issued next.
- R11: The device address sent is `dev_addr` | (bits [6:0] of `reg_addr` shifted right by 8·`addr_len`, masked with `ovf_mask`).
- R12: Each completed READ produces a one-cycle `rx_valid` with `rx_byte` equal to the received byte. Bytes appear in bus order.
- R13: Operation codes on `ctl_op` are 0 = START+byte, 1 = write byte, 2 = read byte, 3 = STOP.
  - `done` is a one-cycle pulse, after which `busy` is low.
  - `start` while `busy` is ignored.
  - Each operation is issued with a single `ctl_go` pulse.
- R14: Register address bytes go most significant first: byte k carries `reg_addr`[8·(`addr_len`−1−k) +: 8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| cmd_read | input | 1 | 1 = read transaction, 0 = write |
| dev_addr | input | 7 | 7-bit device address |
| reg_addr | input | 8·ALEN_MAX | Register address, right-aligned |
| addr_len | input | AL_W | Number of register address bytes |
| data_len | input | DLEN_W | Number of data bytes |
| ovf_mask | input | 7 | Overflow fold mask for device address bits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| result | output | 3 | 0 ok, 1 bad request, 2 NACK, 3 arbitration lost, 4 timeout |
| tx_byte | input | 8 | Next write data byte (show-ahead) |
| tx_take | output | 1 | Consumes `tx_byte` |
| rx_byte | output | 8 | Received data byte |
| rx_valid | output | 1 | `rx_byte` valid |
| bus_busy | input | 1 | Bus currently owned by another master |
| ctl_go | output | 1 | Issue operation to byte controller |
| ctl_op | output | 2 | Operation code |
| ctl_wdata | output | 8 | Byte to send with START or write |
| ctl_ack | output | 1 | Acknowledge to send on a read |
| ctl_done | input | 1 | Operation complete |
| ctl_nack | input | 1 | Byte was not acknowledged |
| ctl_arb_lost | input | 1 | Arbitration lost during the operation |
| ctl_rdata | input | 8 | Byte received by a read |

## Verification
The bench goes after each corner case below; the effect of getting it wrong is given with it.

- **Single-byte read.** The only data byte must be the NACKed one. A design that decides the final byte from a stale count would ACK it and leave the device driving the bus.
- **Address-length edges.** Both zero and four address bytes are exercised, together with the overflow fold. A wrong shift would send address bytes in the wrong order or fold the wrong bits into the device address.
- **Faults at random operation positions.** NACK, arbitration loss and a missing completion are injected at random points. A design that mixes up their priorities would either issue a STOP after losing the bus or keep sending bytes after a NACK.
- **Read completions flagged NACK.** A design that treated these as errors would abort a good read.
- **Ignored requests.** Bad requests and a second `start` arriving mid-transfer must leave the bus untouched.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BUSWAIT,
        ST_DEVW,
        ST_REGA,
        ST_RSTART,
        ST_DATW,
        ST_DATR,
        ST_STOP,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    localparam logic [2:0] RES_OK   = 3'd0;
    localparam logic [2:0] RES_BAD  = 3'd1;
    localparam logic [2:0] RES_NACK = 3'd2;
    localparam logic [2:0] RES_ARB  = 3'd3;
    localparam logic [2:0] RES_TOUT = 3'd4;

endpackage

// File: rtl/seq_dev_fold.sv
module seq_dev_fold #(
    parameter int ALEN_MAX = 4,
    localparam int RA_W = 8 * ALEN_MAX,
    localparam int AL_W = $clog2(ALEN_MAX + 1)
) (
    input  logic [6:0]      dev_i,
    input  logic [RA_W-1:0] reg_addr_i,
    input  logic [AL_W-1:0] alen_i,
    input  logic [6:0]      mask_i,
    output logic [6:0]      dev_o
);
    logic [RA_W+6:0] ext;
    logic [RA_W+6:0] hi;

    always_comb begin
        ext   = {7'd0, reg_addr_i};
        hi    = ext >> {alen_i, 3'b000};
        dev_o = dev_i | (hi[6:0] & mask_i);
    end
endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
    parameter int LIMIT = 50_000_000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2cseq_pkg::*;
#(
    parameter int ALEN_MAX   = 4,
    parameter int DLEN_W     = 16,
    parameter int WAIT_LIMIT = 50_000_000,
    localparam int RA_W = 8 * ALEN_MAX,
    localparam int AL_W = $clog2(ALEN_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_read,
    input  logic [6:0]        dev_addr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [AL_W-1:0]   addr_len,
    input  logic [DLEN_W-1:0] data_len,
    input  logic [6:0]        ovf_mask,
    output logic              busy,
    output logic              done,
    output logic [2:0]        result,
    input  logic [7:0]        tx_byte,
    output logic              tx_take,
    output logic [7:0]        rx_byte,
    output logic              rx_valid,
    input  logic              bus_busy,
    output logic              ctl_go,
    output logic [1:0]        ctl_op,
    output logic [7:0]        ctl_wdata,
    output logic              ctl_ack,
    input  logic              ctl_done,
    input  logic              ctl_nack,
    input  logic              ctl_arb_lost,
    input  logic [7:0]        ctl_rdata
);
    localparam logic [AL_W-1:0]   ALEN_LIM = AL_W'(ALEN_MAX);
    localparam logic [AL_W-1:0]   AL_ONE   = AL_W'(1);
    localparam logic [DLEN_W-1:0] DL_ONE   = DLEN_W'(1);

    seq_state_e        state, succ;
    logic              issued, rd_q, xfer, tmo_run, tmo_hit, bad_req;
    logic [6:0]        dev_q, dev_fold;
    logic [RA_W-1:0]   areg;
    logic [AL_W-1:0]   acnt;
    logic [DLEN_W-1:0] dcnt;
    logic [2:0]        res_q;

    seq_dev_fold #(.ALEN_MAX(ALEN_MAX)) u_fold (
        .dev_i(dev_addr), .reg_addr_i(reg_addr), .alen_i(addr_len),
        .mask_i(ovf_mask), .dev_o(dev_fold)
    );

    seq_wait_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(tmo_run), .expired(tmo_hit)
    );

    assign xfer    = state inside {ST_DEVW, ST_REGA, ST_RSTART, ST_DATW, ST_DATR, ST_STOP};
    assign tmo_run = (state == ST_BUSWAIT && bus_busy) || (xfer && issued && !ctl_done);
    assign bad_req = (data_len == '0) || (addr_len > ALEN_LIM);

    // successor of a byte phase that completed cleanly
    always_comb begin
        unique case (state)
            ST_DEVW:   succ = (acnt != '0) ? ST_REGA : ST_DATW;
            ST_REGA:   succ = (acnt == AL_ONE) ? (rd_q ? ST_RSTART : ST_DATW) : ST_REGA;
            ST_RSTART: succ = ST_DATR;
            ST_DATW:   succ = (dcnt == DL_ONE) ? ST_STOP : ST_DATW;
            ST_DATR:   succ = (dcnt == DL_ONE) ? ST_STOP : ST_DATR;
            default:   succ = ST_STOP;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            issued   <= 1'b0;
            rd_q     <= 1'b0;
            dev_q    <= '0;
            areg     <= '0;
            acnt     <= '0;
            dcnt     <= '0;
            res_q    <= RES_OK;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (ctl_go) issued <= 1'b1;
            unique case (state)
                ST_IDLE: if (start) begin
                    if (bad_req) begin
                        res_q <= RES_BAD;
                        state <= ST_DONE;
                    end else begin
                        res_q <= RES_OK;
                        rd_q  <= cmd_read;
                        dev_q <= dev_fold;
                        areg  <= reg_addr << (8 * (ALEN_MAX - int'(addr_len)));
                        acnt  <= addr_len;
                        dcnt  <= data_len;
                        state <= ST_BUSWAIT;
                    end
                end
                ST_BUSWAIT: begin
                    issued <= 1'b0;
                    if (!bus_busy) begin
                        state <= (rd_q && acnt == '0) ? ST_RSTART : ST_DEVW;
                    end else if (tmo_hit) begin
                        res_q <= RES_TOUT;
                        state <= ST_DONE;
                    end
                end
                ST_DEVW, ST_REGA, ST_RSTART, ST_DATW, ST_DATR: begin
                    if (ctl_done) begin
                        issued <= 1'b0;
                        if (ctl_arb_lost) begin
                            res_q <= RES_ARB;
                            state <= ST_DONE;
                        end else if (ctl_nack && state != ST_DATR) begin
                            res_q <= RES_NACK;
                            state <= ST_STOP;
                        end else begin
                            state <= succ;
                            if (state == ST_REGA) begin
                                areg <= areg << 8;
                                acnt <= acnt - 1'b1;
                            end
                            if (state == ST_DATW || state == ST_DATR) dcnt <= dcnt - 1'b1;
                            if (state == ST_DATR) begin
                                rx_valid <= 1'b1;
                                rx_byte  <= ctl_rdata;
                            end
                        end
                    end else if (tmo_hit) begin
                        issued <= 1'b0;
                        res_q  <= RES_TOUT;
                        state  <= ST_STOP;
                    end
                end
                ST_STOP: if (ctl_done || tmo_hit) state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ctl_op    = OP_STOP;
        ctl_wdata = '0;
        ctl_ack   = 1'b0;
        unique case (state)
            ST_DEVW:   begin ctl_op = OP_START; ctl_wdata = {dev_q, 1'b0}; end
            ST_REGA:   begin ctl_op = OP_WRITE; ctl_wdata = areg[RA_W-1 -: 8]; end
            ST_RSTART: begin ctl_op = OP_START; ctl_wdata = {dev_q, 1'b1}; end
            ST_DATW:   begin ctl_op = OP_WRITE; ctl_wdata = tx_byte; end
            ST_DATR:   begin ctl_op = OP_READ;  ctl_ack = (dcnt != DL_ONE); end
            default:   ctl_op = OP_STOP;
        endcase
        ctl_go  = xfer && !issued;
        tx_take = ctl_go && (state == ST_DATW);
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        result  = res_q;
    end
endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker #(
    parameter int ALEN_MAX = 4,
    parameter int AL_W     = 3,
    parameter int DLEN_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [AL_W-1:0]   addr_len,
    input logic [DLEN_W-1:0] data_len,
    input logic              busy,
    input logic              done,
    input logic [2:0]        result,
    input logic              tx_take,
    input logic              rx_valid,
    input logic              ctl_go,
    input logic [1:0]        ctl_op,
    input logic              ctl_done
);
    p_bad_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (data_len == '0 || int'(addr_len) > ALEN_MAX)) |=> (done && result == 3'd1));

    p_take_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> (ctl_go && ctl_op == 2'd1));

    p_rx_after_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(ctl_done));

    p_go_when_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_go |-> busy);

    p_go_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_go |=> !ctl_go);

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_result_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= 3'd4));
endmodule

bind i2c_xfer_seq i2cseq_checker #(.ALEN_MAX(ALEN_MAX), .AL_W(AL_W), .DLEN_W(DLEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_len(addr_len), .data_len(data_len),
    .busy(busy), .done(done), .result(result), .tx_take(tx_take), .rx_valid(rx_valid),
    .ctl_go(ctl_go), .ctl_op(ctl_op), .ctl_done(ctl_done)
);

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT = 40;

    logic        clk = 0, rst_n = 0, start = 0, cmd_read = 0;
    logic [6:0]  dev_addr = 0, ovf_mask = 0;
    logic [31:0] reg_addr = 0;
    logic [2:0]  addr_len = 0;
    logic [15:0] data_len = 0;
    logic        busy, done, tx_take, rx_valid, ctl_go, ctl_ack;
    logic [2:0]  result;
    logic [7:0]  tx_byte = 0, rx_byte, ctl_wdata, ctl_rdata = 0;
    logic [1:0]  ctl_op;
    logic        bus_busy = 0, ctl_done = 0, ctl_nack = 0, ctl_arb_lost = 0;

    i2c_xfer_seq #(.WAIT_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_read(cmd_read), .dev_addr(dev_addr),
        .reg_addr(reg_addr), .addr_len(addr_len), .data_len(data_len), .ovf_mask(ovf_mask),
        .busy(busy), .done(done), .result(result), .tx_byte(tx_byte), .tx_take(tx_take),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .bus_busy(bus_busy), .ctl_go(ctl_go),
        .ctl_op(ctl_op), .ctl_wdata(ctl_wdata), .ctl_ack(ctl_ack), .ctl_done(ctl_done),
        .ctl_nack(ctl_nack), .ctl_arb_lost(ctl_arb_lost), .ctl_rdata(ctl_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;

    // scenario
    int s_rd, s_dev, s_alen, s_dlen, s_mask, s_nack, s_arb, s_hang, s_busy, s_poke;
    logic [31:0] s_raddr;
    int tx_data[64];
    int rd_data[64];
    // expected and observed
    int e_op[64], e_wd[64], e_ack[64], e_n, e_res, e_rx[64], e_rxn;
    int l_op[64], l_wd[64], l_ack[64], l_n, l_res, l_rx[64], l_rxn;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void add_exp(input int op, input int wd, input int ack);
        e_op[e_n] = op; e_wd[e_n] = wd; e_ack[e_n] = ack; e_n++;
    endfunction

    // expected sequence from the requirements
    function automatic void build_expect();
        logic [39:0] ext;
        int dev, full;
        e_n = 0; e_rxn = 0;
        if (s_dlen == 0 || s_alen > 4) begin e_res = 1; return; end    // R1
        if (s_busy > LIMIT + 5) begin e_res = 4; return; end            // R2
        ext = {8'd0, s_raddr} >> (8 * s_alen);
        dev = s_dev | (int'(ext[6:0]) & s_mask);                        // R11
        if (!s_rd || s_alen > 0) add_exp(0, dev * 2, 0);
        for (int k = 0; k < s_alen; k++) add_exp(1, int'((s_raddr >> (8 * (s_alen - 1 - k))) & 32'hff), 0); // R14
        if (s_rd) begin
            add_exp(0, dev * 2 + 1, 0);
            for (int i = 0; i < s_dlen; i++) add_exp(2, 0, (i != s_dlen - 1) ? 1 : 0);  // R7
        end else begin
            for (int i = 0; i < s_dlen; i++) add_exp(1, tx_data[i], 0);
        end
        full = e_n;
        for (int j = 0; j < full; j++) begin
            if (j == s_hang) begin e_n = j + 1; add_exp(3, 0, 0); e_res = 4; return; end  // R10
            if (j == s_arb) begin e_n = j + 1; e_res = 3; return; end                    // R9
            if (j == s_nack && e_op[j] != 2) begin e_n = j + 1; add_exp(3, 0, 0); e_res = 2; return; end // R8
            if (e_op[j] == 2) begin e_rx[e_rxn] = rd_data[j]; e_rxn++; end
        end
        add_exp(3, 0, 0);
        e_res = 0;
    endfunction

    task automatic run_txn(input string tag);
        int pend, cur, busy_left, cyc, txi;
        bit fin;
        build_expect();
        for (int i = 0; i < 64; i++) begin tx_data[i] = tx_data[i] & 255; rd_data[i] = $urandom_range(0, 255); end
        build_expect();
        @(negedge clk);
        cmd_read = s_rd[0]; dev_addr = s_dev[6:0]; reg_addr = s_raddr; addr_len = s_alen[2:0];
        data_len = s_dlen[15:0]; ovf_mask = s_mask[6:0];
        txi = 0; tx_byte = tx_data[0][7:0];
        busy_left = s_busy; bus_busy = (busy_left > 0);
        start = 1;
        l_n = 0; l_rxn = 0; l_res = -1; pend = -1; cur = 0; cyc = 0; fin = 0;
        while (!fin) begin
            @(negedge clk);
            start = 0; data_len = s_dlen[15:0];
            ctl_done = 0; ctl_nack = 0; ctl_arb_lost = 0;
            if (busy_left > 0) busy_left--;
            bus_busy = (busy_left > 0);
            if (done) begin l_res = int'(result); fin = 1; end
            else begin
                if (rx_valid && l_rxn < 64) begin l_rx[l_rxn] = int'(rx_byte); l_rxn++; end
                if (pend == 0) begin
                    ctl_done = 1;
                    if (l_op[cur] != 3) begin
                        ctl_nack = (cur == s_nack);
                        ctl_arb_lost = (cur == s_arb);
                    end
                    ctl_rdata = rd_data[cur][7:0];
                    pend = -1;
                end else if (pend > 0) pend--;
                if (ctl_go && l_n < 64) begin
                    l_op[l_n] = int'(ctl_op); l_wd[l_n] = int'(ctl_wdata); l_ack[l_n] = int'(ctl_ack);
                    cur = l_n; l_n++;
                    pend = (cur == s_hang && l_op[cur] != 3) ? -1 : $urandom_range(0, 3);
                    if (tx_take) begin txi++; tx_byte = tx_data[txi][7:0]; end
                    if (s_poke != 0 && cur == 0) begin start = 1; data_len = 0; end  // R13 ignored
                end
                cyc++;
                if (cyc > 3000) begin chk(0, "watchdog-txn", cyc, 0); fin = 1; end
            end
        end
        @(negedge clk);
        bus_busy = 0;
        chk(!busy && !done, {tag, " R13 idle after done"}, int'(busy), 0);
        chk(l_res == e_res, {tag, " result"}, l_res, e_res);
        chk(l_n == e_n, {tag, " op count R3"}, l_n, e_n);
        for (int j = 0; j < e_n && j < l_n; j++) begin
            chk(l_op[j] == e_op[j], {tag, " R13 op code"}, l_op[j], e_op[j]);
            if (e_op[j] <= 1) chk(l_wd[j] == e_wd[j], {tag, s_rd ? " R5 byte" : " R3 byte"}, l_wd[j], e_wd[j]);
            if (e_op[j] == 2) chk(l_ack[j] == e_ack[j], {tag, " R7 ack"}, l_ack[j], e_ack[j]);
        end
        chk(l_rxn == e_rxn, {tag, " R12 rx count"}, l_rxn, e_rxn);
        for (int j = 0; j < e_rxn && j < l_rxn; j++)
            chk(l_rx[j] == e_rx[j], {tag, " R12 rx byte"}, l_rx[j], e_rx[j]);
    endtask

    task automatic clear_sc();
        s_rd = 0; s_dev = 7'h50; s_raddr = 32'h0; s_alen = 1; s_dlen = 1; s_mask = 0;
        s_nack = -1; s_arb = -1; s_hang = -1; s_busy = 0; s_poke = 0;
        for (int i = 0; i < 64; i++) tx_data[i] = $urandom_range(0, 255);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !ctl_go && !rx_valid, "R13 reset state", int'(busy), 0);

        clear_sc(); s_dlen = 0; run_txn("R1 zero length");
        clear_sc(); s_alen = 5; run_txn("R1 addr too long");
        clear_sc(); s_busy = LIMIT + 20; run_txn("R2 bus stuck");
        clear_sc(); s_busy = 5; s_dlen = 3; run_txn("R2 short busy, R3 write");
        clear_sc(); s_alen = 0; s_dlen = 2; run_txn("R4 write no addr");
        clear_sc(); s_alen = 4; s_raddr = 32'hA1B2C3D4; s_dlen = 2; s_mask = 7'h7; run_txn("R14 four addr bytes");
        clear_sc(); s_alen = 1; s_raddr = 32'h0000_0356; s_mask = 7'h3; s_dev = 7'h50; run_txn("R11 fold");
        clear_sc(); s_rd = 1; s_alen = 0; s_dlen = 1; run_txn("R6 probe ack");
        clear_sc(); s_rd = 1; s_alen = 0; s_dlen = 1; s_nack = 0; run_txn("R6 probe nack");
        clear_sc(); s_rd = 1; s_alen = 2; s_raddr = 32'h1234; s_dlen = 1; run_txn("R5 R7 single read");
        clear_sc(); s_rd = 1; s_alen = 2; s_dlen = 4; s_nack = 5; run_txn("R8 nack on read ignored");
        clear_sc(); s_alen = 2; s_dlen = 3; s_nack = 2; run_txn("R8 nack reg byte");
        clear_sc(); s_rd = 1; s_alen = 1; s_dlen = 3; s_arb = 4; run_txn("R9 arb on read");
        clear_sc(); s_dlen = 3; s_hang = 2; run_txn("R10 byte hang");
        clear_sc(); s_rd = 1; s_dlen = 3; s_poke = 1; run_txn("R13 start ignored while busy");

        for (int t = 0; t < 60; t++) begin
            clear_sc();
            s_rd = $urandom_range(0, 1);
            s_dev = $urandom_range(0, 127);
            s_raddr = $urandom;
            s_alen = $urandom_range(0, 4);
            s_dlen = $urandom_range(1, 8);
            s_mask = ($urandom_range(0, 1) != 0) ? $urandom_range(0, 127) : 0;
            if ($urandom_range(0, 3) == 0) s_nack = $urandom_range(0, 12);
            if ($urandom_range(0, 7) == 0) s_arb = $urandom_range(0, 12);
            if ($urandom_range(0, 9) == 0) s_hang = $urandom_range(0, 12);
            s_busy = $urandom_range(0, 4);
            run_txn(s_rd ? "R5 random read" : "R3 random write");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule